// File: doc/BRIEF.md
# Page Access Checker with Fault Logging

This block sits behind a page-table walker. The walker supplies the leaf entry it found. The block receives that entry's 3-bit permission code and its modified (dirty) bit, together with the kind of access (load, store, instruction fetch) and whether the requester runs in supervisor or user mode. The block does two things:

- It decides whether the access is legal and returns a fault code.
- It returns the read, write and execute rights that may be cached for the page. Write rights are held back until the page has been marked modified, so the first store still goes through the walker and the dirty bit can be set.

When an access faults, the block records the event in two registers. The fault status register holds the access kind, the fault code, an address-valid flag and an overflow flag. The fault address register holds the page-aligned faulting address. Software reads the status register through a read strobe, and that read clears it. If a second fault arrives before software has read the first, the status register reports an overflow. A no-fault mode lets user-mode accesses proceed without logging a fault.

The register logic is a two-state machine. The states are ST_EMPTY (status is zero) and ST_HELD (a fault record is pending). The transitions are:

- **record**: ST_EMPTY to ST_HELD, on a fault.
- **stack**: ST_HELD to ST_HELD, on a fault with no read in the same cycle. This sets the overflow flag.
- **drain**: ST_HELD to ST_EMPTY, on a read with no fault in the same cycle.
- **replace**: ST_HELD to ST_HELD, on a read and a fault in the same cycle. This writes a fresh record with no overflow.

Top module: `acc_chk_top`

## Requirements
- R1: The access index is {write, fetch, supervisor} as bits 2, 1 and 0. On a fault it is stored in status bits 7:5.
- R2: A user access to an entry with permission code 6 or 7 returns fault code 12 (privilege violation).
- R3: Apart from the R2 case, an access returns fault code 8 (protection) when its needed rights are not all granted, and 0 otherwise. A load needs R and nothing else. A store needs W. A fetch needs X. A store that is also a fetch needs both W and X.
- R4: User rights per permission code 0 to 7 are R, RW, RX, RWX, X, R, none, none. They are output as perm_r, perm_w and perm_x.
- R5: Supervisor rights match the user rights for codes 0 to 4. For codes 5, 6 and 7 they are RW, RX and RWX.
- R6: perm_w is 0 whenever the modified input is 0, even if the code grants write. The fault check itself uses the ungated rights.
- R7: With nofault_en=1, a user access with a nonzero check result gives fault_code 0 and leaves both registers unchanged. Supervisor accesses still fault.
- R8: A fault taken while chk_valid=1 loads the status register with (base | index<<5 | code | 2). base is 1 if the status was already nonzero and no read occurs in that cycle, and 0 otherwise. The same fault loads the address register with vaddr with its low PAGE_BITS bits cleared. Both values are visible one cycle later.
- R9: While stat_rd=1, stat_q shows the current status. When no fault occurs in that cycle, the status is 0 from the next cycle on.
- R10: With stat_rd=1 and a fault in the same cycle, stat_q shows the old status and the new record carries no overflow bit.
- R11: After reset, stat_q and addr_q are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| chk_valid | input | 1 | One-cycle strobe: check this access and log any fault |
| acc_write | input | 1 | Access is a store |
| acc_fetch | input | 1 | Access is an instruction fetch |
| acc_super | input | 1 | Requester is in supervisor mode |
| perm_code | input | 3 | Permission code of the leaf entry |
| modified | input | 1 | Modified bit of the leaf entry |
| nofault_en | input | 1 | No-fault mode for user accesses |
| vaddr | input | ADDR_W | Virtual address of the access |
| stat_rd | input | 1 | Software read strobe for the status register |
| fault_code | output | 4 | 0 = allowed, 8 = protection, 12 = privilege |
| perm_r | output | 1 | Read right granted |
| perm_w | output | 1 | Write right granted (gated by modified) |
| perm_x | output | 1 | Execute right granted |
| stat_q | output | 8 | Fault status register |
| addr_q | output | ADDR_W | Fault address register |

## Verification
The bench builds the block with ADDR_W=24 and PAGE_BITS=10. This ensures the address-alignment mask is computed from the parameters rather than assumed to be 4 KB. With a narrow address, the bench can put ones in every bit position that must be cleared and check that each one is cleared. The bench sweeps all 64 pairs of access index and permission code with alternating dirty bits and a read on every cycle, which exercises the replace transition. Separate sequences exercise stacking into overflow, draining, and no-fault mode for both privilege levels.

// File: rtl/acc_chk_pkg.sv
package acc_chk_pkg;
    localparam int IDX_W  = 3;
    localparam int CODE_W = 4;
    localparam int STAT_W = IDX_W + 5;

    localparam logic [CODE_W-1:0] FC_NONE = 4'd0;
    localparam logic [CODE_W-1:0] FC_PROT = 4'd8;
    localparam logic [CODE_W-1:0] FC_PRIV = 4'd12;

    typedef struct packed {
        logic r;
        logic w;
        logic x;
    } perm_t;

    typedef enum logic {
        ST_EMPTY,
        ST_HELD
    } log_state_t;
endpackage

// File: rtl/acc_decode.sv
module acc_decode
    import acc_chk_pkg::*;
(
    input  logic                acc_write,
    input  logic                acc_fetch,
    input  logic                acc_super,
    input  logic [2:0]          perm_code,
    output logic [IDX_W-1:0]    acc_index,
    output logic [CODE_W-1:0]   check_code,
    output perm_t               grant
);
    perm_t need;
    logic  missing;
    logic  priv_bad;

    // R1 access index layout
    assign acc_index = {acc_write, acc_fetch, acc_super};

    // R4 R5 rights per code and privilege
    always_comb begin
        unique case (perm_code)
            3'd0: grant = '{r: 1'b1, w: 1'b0, x: 1'b0};
            3'd1: grant = '{r: 1'b1, w: 1'b1, x: 1'b0};
            3'd2: grant = '{r: 1'b1, w: 1'b0, x: 1'b1};
            3'd3: grant = '{r: 1'b1, w: 1'b1, x: 1'b1};
            3'd4: grant = '{r: 1'b0, w: 1'b0, x: 1'b1};
            3'd5: grant = '{r: 1'b1, w: acc_super, x: 1'b0};
            3'd6: grant = '{r: acc_super, w: 1'b0, x: acc_super};
            default: grant = '{r: acc_super, w: acc_super, x: acc_super};
        endcase
    end

    always_comb begin
        need.r   = !acc_write && !acc_fetch;
        need.w   = acc_write;
        need.x   = acc_fetch;
        missing  = (need.r && !grant.r) || (need.w && !grant.w) || (need.x && !grant.x);
        priv_bad = !acc_super && perm_code[2] && perm_code[1];
        if (priv_bad)      check_code = FC_PRIV;   // R2
        else if (missing)  check_code = FC_PROT;   // R3
        else               check_code = FC_NONE;
    end

    always_comb begin
        if (check_code == FC_PRIV) begin
            AST_PRIV_ONLY_USER: assert (!acc_super); // R2
        end
        if (check_code == FC_NONE && !acc_write && !acc_fetch) begin
            AST_LOAD_HAS_READ: assert (grant.r); // R3
        end
    end
endmodule

// File: rtl/fault_log.sv
module fault_log
    import acc_chk_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int PAGE_BITS = 12
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                fault_take,
    input  logic [IDX_W-1:0]    acc_index,
    input  logic [CODE_W-1:0]   code,
    input  logic [ADDR_W-1:0]   vaddr,
    input  logic                stat_rd,
    output logic [STAT_W-1:0]   stat_q,
    output logic [ADDR_W-1:0]   addr_q
);
    localparam logic [ADDR_W-1:0] PAGE_MASK = {ADDR_W{1'b1}} << PAGE_BITS;

    log_state_t          state_q, state_d;
    logic [STAT_W-1:0]   stat_d;
    logic [ADDR_W-1:0]   addr_d;
    logic [STAT_W-1:0]   record;

    assign record = {acc_index, 5'b0} | STAT_W'(code) | STAT_W'(2);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_EMPTY;
            stat_q  <= '0;
            addr_q  <= '0;
        end else begin
            state_q <= state_d;
            stat_q  <= stat_d;
            addr_q  <= addr_d;
        end
    end

    always_comb begin
        state_d = state_q;
        stat_d  = stat_q;
        addr_d  = addr_q;
        unique case (state_q)
            ST_EMPTY: begin
                if (fault_take) begin           // record
                    state_d = ST_HELD;
                    stat_d  = record;
                    addr_d  = vaddr & PAGE_MASK;
                end
            end
            ST_HELD: begin
                if (fault_take && !stat_rd) begin       // stack (R8)
                    stat_d = record | STAT_W'(1);
                    addr_d = vaddr & PAGE_MASK;
                end else if (fault_take) begin          // replace (R10)
                    stat_d = record;
                    addr_d = vaddr & PAGE_MASK;
                end else if (stat_rd) begin             // drain (R9)
                    state_d = ST_EMPTY;
                    stat_d  = '0;
                end
            end
            default: state_d = ST_EMPTY;
        endcase
    end

    AST_CLEAR_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
        stat_rd && !fault_take |=> stat_q == '0); // R9
    AST_VALID_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        fault_take |=> stat_q[1]); // R8
    AST_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        fault_take && stat_q != '0 && !stat_rd |=> stat_q[0]); // R8
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        fault_take && stat_rd |=> !stat_q[0]); // R10
    AST_ADDR_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        fault_take |=> addr_q[PAGE_BITS-1:0] == '0); // R8
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !fault_take && !stat_rd |=> $stable(stat_q) && $stable(addr_q)); // R7
endmodule

// File: rtl/acc_chk_top.sv
module acc_chk_top
    import acc_chk_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int PAGE_BITS = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              chk_valid,
    input  logic              acc_write,
    input  logic              acc_fetch,
    input  logic              acc_super,
    input  logic [2:0]        perm_code,
    input  logic              modified,
    input  logic              nofault_en,
    input  logic [ADDR_W-1:0] vaddr,
    input  logic              stat_rd,
    output logic [3:0]        fault_code,
    output logic              perm_r,
    output logic              perm_w,
    output logic              perm_x,
    output logic [7:0]        stat_q,
    output logic [ADDR_W-1:0] addr_q
);
    logic [IDX_W-1:0]  acc_index;
    logic [CODE_W-1:0] check_code;
    perm_t             grant;
    logic              suppress;
    logic              fault_take;

    acc_decode u_dec (
        .acc_write  (acc_write),
        .acc_fetch  (acc_fetch),
        .acc_super  (acc_super),
        .perm_code  (perm_code),
        .acc_index  (acc_index),
        .check_code (check_code),
        .grant      (grant)
    );

    // R7 no-fault mode applies to user accesses only
    assign suppress   = nofault_en && !acc_super;
    assign fault_take = chk_valid && (check_code != FC_NONE) && !suppress;
    assign fault_code = fault_take ? check_code : FC_NONE;

    // R6 withhold write until dirty
    assign perm_r = grant.r;
    assign perm_w = grant.w && modified;
    assign perm_x = grant.x;

    fault_log #(.ADDR_W(ADDR_W), .PAGE_BITS(PAGE_BITS)) u_log (
        .clk        (clk),
        .rst_n      (rst_n),
        .fault_take (fault_take),
        .acc_index  (acc_index),
        .code       (check_code),
        .vaddr      (vaddr),
        .stat_rd    (stat_rd),
        .stat_q     (stat_q),
        .addr_q     (addr_q)
    );

    AST_WRITE_NEEDS_DIRTY: assert property (@(posedge clk) disable iff (!rst_n)
        perm_w |-> modified); // R6
    AST_NOFAULT_USER: assert property (@(posedge clk) disable iff (!rst_n)
        chk_valid && nofault_en && !acc_super && !stat_rd |=> $stable(stat_q)); // R7
endmodule

// File: tb/acc_chk_top_test.sv
module acc_chk_top_test;
    localparam int AW = 24;
    localparam int PB = 10;

    logic clk = 0, rst_n = 0;
    logic chk_valid = 0, acc_write = 0, acc_fetch = 0, acc_super = 0;
    logic [2:0] perm_code = 0;
    logic modified = 0, nofault_en = 0, stat_rd = 0;
    logic [AW-1:0] vaddr = 0;
    logic [3:0] fault_code;
    logic perm_r, perm_w, perm_x;
    logic [7:0] stat_q;
    logic [AW-1:0] addr_q;

    always #2.5 clk = ~clk;

    acc_chk_top #(.ADDR_W(AW), .PAGE_BITS(PB)) uut (
        .clk(clk), .rst_n(rst_n), .chk_valid(chk_valid), .acc_write(acc_write),
        .acc_fetch(acc_fetch), .acc_super(acc_super), .perm_code(perm_code),
        .modified(modified), .nofault_en(nofault_en), .vaddr(vaddr),
        .stat_rd(stat_rd), .fault_code(fault_code), .perm_r(perm_r),
        .perm_w(perm_w), .perm_x(perm_x), .stat_q(stat_q), .addr_q(addr_q)
    );

    typedef struct {
        string      tag;
        logic [3:0] fc;
        logic [2:0] rwx;
        logic [7:0] rdv;
        logic [7:0] stat;
        logic [AW-1:0] addr;
    } exp_t;

    exp_t q[$];
    int n_chk = 0, n_fail = 0;
    logic [7:0] m_stat = 0;
    logic [AW-1:0] m_addr = 0;
    bit done = 0;

    // 8x8 check table, rows = access index, columns = permission code
    function automatic logic [3:0] tbl(input logic [2:0] i, input logic [2:0] c);
        logic [3:0] t [8][8] = '{
            '{0,0,0,0,8,0,12,12}, '{0,0,0,0,8,0,0,0},
            '{8,8,0,0,0,8,12,12}, '{8,8,0,0,0,8,0,0},
            '{8,0,8,0,8,8,12,12}, '{8,0,8,0,8,0,8,0},
            '{8,8,8,0,8,8,12,12}, '{8,8,8,0,8,8,8,0}};
        return t[i][c];
    endfunction

    function automatic logic [2:0] rights(input logic s, input logic [2:0] c);
        logic [2:0] u [8] = '{3'b100,3'b110,3'b101,3'b111,3'b001,3'b100,3'b000,3'b000};
        logic [2:0] k [8] = '{3'b100,3'b110,3'b101,3'b111,3'b001,3'b110,3'b101,3'b111};
        return s ? k[c] : u[c];
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic drive(input string tag, input logic w, input logic x, input logic s,
                         input logic [2:0] c, input logic m, input logic nf,
                         input logic [AW-1:0] a, input logic rd);
        exp_t e;
        logic [2:0] idx;
        logic [3:0] code;
        logic take;
        @(negedge clk);
        chk_valid = 1; acc_write = w; acc_fetch = x; acc_super = s;
        perm_code = c; modified = m; nofault_en = nf; vaddr = a; stat_rd = rd;
        idx  = {w, x, s};
        code = tbl(idx, c);
        take = (code != 0) && !(nf && !s);
        e.tag = tag;
        e.fc  = take ? code : 4'd0;
        e.rwx = rights(s, c) & {1'b1, m, 1'b1};
        e.rdv = m_stat;
        if (take) begin
            m_stat = ((m_stat != 0 && !rd) ? 8'd1 : 8'd0) | {idx, 5'b0} | {4'b0, code} | 8'd2;
            m_addr = a & ~((AW'(1) << PB) - 1);
        end else if (rd) begin
            m_stat = 0;
        end
        e.stat = m_stat;
        e.addr = m_addr;
        q.push_back(e);
    endtask

    task automatic idle();
        @(negedge clk);
        chk_valid = 0; stat_rd = 0;
    endtask

    // monitor: registered results of the previous item, then this item's combinational outputs
    initial begin
        exp_t pend;
        bit have = 0;
        forever begin
            @(negedge clk);
            #2;
            if (have) begin
                chk({pend.tag, " stat"}, stat_q, pend.stat);
                chk({pend.tag, " addr"}, addr_q, pend.addr);
                have = 0;
            end
            if (q.size() != 0 && chk_valid) begin
                pend = q.pop_front();
                chk({pend.tag, " code"}, fault_code, pend.fc);
                chk({pend.tag, " rights"}, {perm_r, perm_w, perm_x}, pend.rwx);
                if (stat_rd) chk({pend.tag, " readval"}, stat_q, pend.rdv);
                have = 1;
            end
        end
    end

    initial begin
        #200000;
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        #12 rst_n = 1;
        @(negedge clk); #1;
        chk("R11 reset stat", stat_q, 0);
        chk("R11 reset addr", addr_q, 0);
        // sweep: R1 R2 R3 R4 R5 R6 R10 with read every cycle
        for (int i = 0; i < 8; i++)
            for (int c = 0; c < 8; c++)
                drive("R3 sweep", i[2], i[1], i[0], c[2:0], c[0] ^ i[0], 0,
                      AW'(i * 8 + c) * AW'(24'h1357) | AW'(24'h3ff), 1);
        drive("R9 drain", 0, 0, 0, 0, 1, 0, 0, 1);
        drive("R9 drained", 0, 0, 0, 0, 1, 0, 0, 1);
        // R8 stack into overflow
        drive("R2 user priv", 0, 0, 0, 3'd6, 0, 0, 24'hABCDEF, 0);
        drive("R8 overflow", 1, 0, 1, 3'd4, 1, 0, 24'h123FFF, 0);
        idle();
        drive("R1 read record", 0, 0, 1, 3'd3, 1, 0, 0, 1);
        // R7 no-fault mode
        drive("R7 user suppressed", 1, 0, 0, 3'd0, 0, 1, 24'h55AAFF, 0);
        drive("R7 user priv suppressed", 0, 1, 0, 3'd7, 0, 1, 24'h0003FF, 0);
        drive("R7 super still faults", 1, 0, 1, 3'd2, 0, 1, 24'hFEDCBA, 0);
        drive("R6 dirty write", 1, 0, 1, 3'd5, 1, 0, 0, 1);
        drive("R6 clean write", 1, 0, 1, 3'd5, 0, 0, 0, 1);
        drive("R5 super exec", 0, 1, 1, 3'd6, 1, 0, 0, 0);
        drive("R4 user exec", 0, 1, 0, 3'd4, 1, 0, 0, 0);
        idle();
        idle();
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule